// File: doc/BRIEF.md
# Dot-Matrix Scan and Attribute Engine

This block drives eight 5x7 dot-matrix characters from the contents of an external register file. It reads eight character codes, eight per-digit flash bits, five attribute control bits and the custom-glyph pixel store. From these it produces a one-hot row select and twenty column enables. Each code is decoded either through a small placeholder font table or as an index into the custom-glyph store. The engine splits the eight digits into two groups of four. It scans the seven pixel rows of each group in turn, which gives fourteen display cycles per frame.

All timing comes from a display tick. The tick is either an internal divided clock (master) or an external tick input (slave). In master mode the tick is also driven out, so other engines can follow it. A slow phase, derived from the same tick, gates flashing digits and whole-display blink. A quantised duty cycle inside each display cycle sets brightness. Displays that share the tick and the reset stay in step.

Top module: `matrix_scan_engine`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `row_sel` and `col_en` are 0. Reset also returns the slot, cycle, tick-divider and slow-phase counters to zero, so the scan restarts at cycle 0, slot 0 in the visible phase.
- R2: One display cycle lasts 16 display ticks, numbered as slots 0..15. Cycles 0..13 repeat in order. Cycle c shows row c mod 7 of digits 4*(c/7)..4*(c/7)+3, and `row_sel` is the one-hot vector with bit c set. Outputs follow the internal state with one clock of latency.
- R3: `col_en[5k+4:5k]` is digit position k of the group, and bit 5k+4 is the leftmost column. When a code has bit 7 = 0, its row r is 0 for code[6:0] = 0x20 and otherwise (code[4:0] + r) mod 32. When bit 7 = 1, its row r is `glyph_bits[(g*7+r)*5 +: 5]` with g = code[3:0]. A pixel bit of 1 lights the column.
- R4: `attr_ctrl[2:0]` sets the number of lit slots per cycle (slots 0..n-1): 000→15, 001→12, 010→8, 011→6, 100→4, 101→3, 110→2, 111→0 (blank). Slot 15 is always dark.
- R5: With `attr_ctrl[3]` = 1, during the dark slow phase, a digit whose `flash_bits` bit is set shows no columns. With `attr_ctrl[3]` = 0, `flash_bits` has no effect.
- R6: With `attr_ctrl[4]` = 1, all columns are dark during the dark slow phase, whatever the flash settings.
- R7: The slow phase starts visible after reset and toggles every 14336 display ticks, so a full on/off period is 28672 ticks.
- R8: The pixel rows for a display cycle are captured on the tick that enters that cycle. A change of codes or glyphs during a cycle shows from the next cycle on. The first cycle after reset is dark.
- R9: With `clk_sel` = 1, the display tick comes from an internal divider that fires every 4 clocks, `ext_tick` is ignored, and `clk_out` pulses one clock after each internal tick. With `clk_sel` = 0, the tick is `ext_tick` and `clk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 1 | 1 = internal tick (master), 0 = external tick (slave) |
| ext_tick | input | 1 | External display tick, one-clock pulse |
| attr_ctrl | input | 5 | [4] blink, [3] flash enable, [2:0] brightness level |
| char_codes | input | 64 | Eight 8-bit character codes, digit d at [8d+7:8d] |
| flash_bits | input | 8 | Per-digit flash select, bit d for digit d |
| glyph_bits | input | 560 | Custom glyph store, 16 glyphs x 7 rows x 5 bits |
| row_sel | output | 14 | One-hot row-group select, bit = display cycle |
| col_en | output | 20 | Column enables, four digits of five columns |
| clk_out | output | 1 | Display tick driven out in master mode |

## Verification
Every output is registered from the scan state: `row_sel` and `col_en` show the slot and cycle reached by the previous clock. New pixel data is only seen after the tick that enters a cycle, and `clk_out` trails the internal divider tick by one clock. The bench keeps a reference model that it advances at each rising edge, using the same inputs the design sees. The model's expected values therefore carry exactly this one-clock lag and the cycle-start capture. All comparisons are made on the falling edge, half a period after the outputs settle. Slow-phase checks run across the 14336 and 28672 tick marks, so each toggle is seen in the slot where it is due.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int GLYPH_W    = 5;
  localparam int GLYPH_H    = 7;
  localparam int CODE_W     = 8;
  localparam int ATTR_W     = 5;
  localparam int FLASH_BIT  = 3;
  localparam int BLINK_BIT  = 4;
  localparam logic [6:0] SPACE_CODE = 7'h20;

  // nominal brightness in percent for each level
  function automatic int unsigned level_pct(input logic [2:0] lvl);
    unique case (lvl)
      3'd0:    return 100;
      3'd1:    return 80;
      3'd2:    return 53;
      3'd3:    return 40;
      3'd4:    return 27;
      3'd5:    return 20;
      3'd6:    return 13;
      default: return 0;
    endcase
  endfunction

  // lit slots out of span, rounded to nearest
  function automatic int unsigned lit_slots(input logic [2:0] lvl, input int unsigned span);
    return (level_pct(lvl) * span + 50) / 100;
  endfunction

  // placeholder font: blank for space, otherwise a simple computed pattern
  function automatic logic [GLYPH_W-1:0] font_row(input logic [6:0] code, input logic [2:0] row);
    if (code == SPACE_CODE) return '0;
    return code[4:0] + {2'b00, row};
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int SLOTS        = 16,
  parameter int CYCLES       = 14,
  parameter int BLINK_PERIOD = 28672,
  parameter int INT_DIV      = 4,
  parameter int POS_W        = 4,
  parameter int CYC_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_sel,
  input  logic             ext_tick,
  output logic [POS_W-1:0] pos,
  output logic [CYC_W-1:0] cyc,
  output logic [CYC_W-1:0] nxt_cyc,
  output logic             load,
  output logic             phase,
  output logic             clk_out
);
  localparam int HALF   = BLINK_PERIOD / 2;
  localparam int HALF_W = $clog2(HALF);
  localparam int DIV_W  = $clog2(INT_DIV + 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [HALF_W-1:0] half_cnt;
  logic              int_tick, tick, pos_last;

  assign int_tick = (div_cnt == DIV_W'(INT_DIV - 1));
  assign tick     = clk_sel ? int_tick : ext_tick;
  assign pos_last = (pos == POS_W'(SLOTS - 1));
  assign load     = tick && pos_last;
  assign nxt_cyc  = (cyc == CYC_W'(CYCLES - 1)) ? '0 : cyc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      clk_out  <= 1'b0;
      pos      <= '0;
      cyc      <= '0;
      half_cnt <= '0;
      phase    <= 1'b0;
    end else begin
      div_cnt <= int_tick ? '0 : div_cnt + 1'b1;
      clk_out <= clk_sel && int_tick;
      if (tick) begin
        pos <= pos_last ? '0 : pos + 1'b1;
        if (pos_last) cyc <= nxt_cyc;
        if (half_cnt == HALF_W'(HALF - 1)) begin
          half_cnt <= '0;
          phase    <= ~phase;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  AST_CLKOUT_SLAVE: assert property (@(posedge clk) disable iff (rst) !clk_sel |=> !clk_out); // R9
  AST_PHASE_HOLD:   assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(phase)); // R7
  AST_CYC_RANGE:    assert property (@(posedge clk) disable iff (rst) cyc < CYC_W'(CYCLES)); // R2
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DPG        = 4,
  parameter int GLYPHS     = 16,
  parameter int CYC_W      = 4,
  parameter int IDX_W      = 4
) (
  input  logic [CYC_W-1:0]                   cyc_sel,
  input  logic [NUM_DIGITS*CODE_W-1:0]       codes,
  input  logic [GLYPHS*GLYPH_H*GLYPH_W-1:0]  glyphs,
  output logic [DPG*GLYPH_W-1:0]             pix
);
  int         grp;
  logic [2:0] row;

  always_comb begin
    grp = int'(cyc_sel) / GLYPH_H;
    row = 3'(int'(cyc_sel) % GLYPH_H);
  end

  for (genvar k = 0; k < DPG; k++) begin : g_digit
    logic [CODE_W-1:0]  code_k;
    logic [IDX_W-1:0]   idx;
    logic [GLYPH_W-1:0] custom;
    always_comb begin
      code_k = codes[(grp * DPG + k) * CODE_W +: CODE_W];
      idx    = code_k[IDX_W-1:0];
      custom = glyphs[(int'(idx) * GLYPH_H + int'(row)) * GLYPH_W +: GLYPH_W];
      pix[k*GLYPH_W +: GLYPH_W] = code_k[CODE_W-1] ? custom : font_row(code_k[6:0], row);
    end
  end
endmodule

// File: rtl/col_driver.sv
module col_driver
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DPG        = 4,
  parameter int SLOTS      = 16,
  parameter int CYCLES     = 14,
  parameter int POS_W      = 4,
  parameter int CYC_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [DPG*GLYPH_W-1:0] pix_next,
  input  logic [POS_W-1:0]       pos,
  input  logic [CYC_W-1:0]       cyc,
  input  logic                   phase,
  input  logic [ATTR_W-1:0]      attr,
  input  logic [NUM_DIGITS-1:0]  flash,
  output logic [CYCLES-1:0]      row_sel,
  output logic [DPG*GLYPH_W-1:0] col_en
);
  localparam int COLW = DPG * GLYPH_W;

  logic [COLW-1:0] pix_q, keep;
  logic            lit;
  int              grp;

  always_comb begin
    grp = int'(cyc) / GLYPH_H;
    for (int k = 0; k < DPG; k++)
      keep[k*GLYPH_W +: GLYPH_W] = {GLYPH_W{~(attr[FLASH_BIT] && phase && flash[grp*DPG + k])}};
    lit = (int'(pos) < int'(lit_slots(attr[2:0], SLOTS - 1))) && !(attr[BLINK_BIT] && phase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q   <= '0;
      row_sel <= '0;
      col_en  <= '0;
    end else begin
      if (load) pix_q <= pix_next;
      row_sel <= CYCLES'(1) << cyc;
      col_en  <= lit ? (pix_q & keep) : '0;
    end
  end

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst) (col_en != '0) |-> $onehot(row_sel)); // R2
  AST_GAP_DARK:   assert property (@(posedge clk) disable iff (rst) (pos == POS_W'(SLOTS - 1)) |=> (col_en == '0)); // R4
  AST_BLANK_LVL:  assert property (@(posedge clk) disable iff (rst) (attr[2:0] == 3'b111) |=> (col_en == '0)); // R4
  AST_BLINK_DARK: assert property (@(posedge clk) disable iff (rst) (attr[BLINK_BIT] && phase) |=> (col_en == '0)); // R6
endmodule

// File: rtl/matrix_scan_engine.sv
module matrix_scan_engine
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS       = 8,
  parameter int DIGITS_PER_GROUP = 4,
  parameter int GLYPHS           = 16,
  parameter int SLOTS            = 16,
  parameter int BLINK_PERIOD     = 28672,
  parameter int INT_DIV          = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          clk_sel,
  input  logic                                          ext_tick,
  input  logic [ATTR_W-1:0]                             attr_ctrl,
  input  logic [NUM_DIGITS*CODE_W-1:0]                  char_codes,
  input  logic [NUM_DIGITS-1:0]                         flash_bits,
  input  logic [GLYPHS*GLYPH_H*GLYPH_W-1:0]             glyph_bits,
  output logic [(NUM_DIGITS/DIGITS_PER_GROUP)*GLYPH_H-1:0] row_sel,
  output logic [DIGITS_PER_GROUP*GLYPH_W-1:0]           col_en,
  output logic                                          clk_out
);
  localparam int GROUPS = NUM_DIGITS / DIGITS_PER_GROUP;
  localparam int CYCLES = GROUPS * GLYPH_H;
  localparam int POS_W  = $clog2(SLOTS);
  localparam int CYC_W  = $clog2(CYCLES);
  localparam int IDX_W  = $clog2(GLYPHS);
  localparam int COLW   = DIGITS_PER_GROUP * GLYPH_W;

  logic [POS_W-1:0] pos;
  logic [CYC_W-1:0] cyc, nxt_cyc;
  logic             load, phase;
  logic [COLW-1:0]  pix_next;

  scan_timer #(
    .SLOTS(SLOTS), .CYCLES(CYCLES), .BLINK_PERIOD(BLINK_PERIOD),
    .INT_DIV(INT_DIV), .POS_W(POS_W), .CYC_W(CYC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .pos(pos), .cyc(cyc), .nxt_cyc(nxt_cyc), .load(load),
    .phase(phase), .clk_out(clk_out)
  );

  glyph_fetch #(
    .NUM_DIGITS(NUM_DIGITS), .DPG(DIGITS_PER_GROUP), .GLYPHS(GLYPHS),
    .CYC_W(CYC_W), .IDX_W(IDX_W)
  ) u_fetch (
    .cyc_sel(nxt_cyc), .codes(char_codes), .glyphs(glyph_bits), .pix(pix_next)
  );

  col_driver #(
    .NUM_DIGITS(NUM_DIGITS), .DPG(DIGITS_PER_GROUP), .SLOTS(SLOTS),
    .CYCLES(CYCLES), .POS_W(POS_W), .CYC_W(CYC_W)
  ) u_cols (
    .clk(clk), .rst(rst), .load(load), .pix_next(pix_next), .pos(pos),
    .cyc(cyc), .phase(phase), .attr(attr_ctrl), .flash(flash_bits),
    .row_sel(row_sel), .col_en(col_en)
  );
endmodule

// File: tb/test_matrix_scan_engine.sv
module test_matrix_scan_engine;
  logic         clk = 1'b0;
  logic         rst, clk_sel, ext_tick;
  logic [4:0]   attr;
  logic [7:0]   codes [8];
  logic [4:0]   glyph [16][7];
  logic [7:0]   flash;
  logic [63:0]  codes_flat;
  logic [559:0] glyph_flat;
  logic [13:0]  row_sel;
  logic [19:0]  col_en;
  logic         clk_out;

  int    n_chk = 0, n_bad = 0;
  bit    chk_on = 0, done = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  always_comb begin
    for (int d = 0; d < 8; d++) codes_flat[d*8 +: 8] = codes[d];
    for (int g = 0; g < 16; g++)
      for (int r = 0; r < 7; r++) glyph_flat[(g*7+r)*5 +: 5] = glyph[g][r];
  end

  matrix_scan_engine i_matrix_scan_engine (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .attr_ctrl(attr), .char_codes(codes_flat), .flash_bits(flash),
    .glyph_bits(glyph_flat), .row_sel(row_sel), .col_en(col_en), .clk_out(clk_out)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected pixel rows for a display cycle (R3)
  function automatic logic [19:0] exp_pix(int c);
    logic [19:0] p;
    int g, row;
    g = c / 7; row = c % 7;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] cd;
      cd = codes[g*4 + k];
      if (cd[7]) p[k*5 +: 5] = glyph[cd[3:0]][row];
      else if (cd[6:0] == 7'h20) p[k*5 +: 5] = 5'd0;
      else p[k*5 +: 5] = 5'(cd[4:0] + 5'(row));
    end
    return p;
  endfunction

  // expected column enables (R4, R5, R6)
  function automatic logic [19:0] exp_col(logic [19:0] pix, int pos, int c, bit ph,
                                          logic [4:0] a, logic [7:0] fl);
    int on_tab [8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    logic [19:0] r;
    if (pos >= on_tab[a[2:0]]) return 20'd0;
    if (a[4] && ph) return 20'd0;
    r = pix;
    for (int k = 0; k < 4; k++)
      if (a[3] && ph && fl[(c/7)*4 + k]) r[k*5 +: 5] = 5'd0;
    return r;
  endfunction

  // reference model, advanced at each rising edge
  int          m_div, m_pos, m_cyc, m_half;
  bit          m_ph, int_t, tk;
  logic [19:0] m_pix, e_col;
  logic [13:0] e_row;
  logic        e_clk;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_pos = 0; m_cyc = 0; m_half = 0; m_ph = 0; m_pix = '0;
      e_row = '0; e_col = '0; e_clk = 1'b0;
    end else begin
      e_row = 14'(1) << m_cyc;
      e_col = exp_col(m_pix, m_pos, m_cyc, m_ph, attr, flash);
      int_t = (m_div == 3);
      e_clk = clk_sel && int_t;
      tk    = clk_sel ? int_t : ext_tick;
      m_div = int_t ? 0 : m_div + 1;
      if (tk) begin
        if (m_pos == 15) begin
          m_pos = 0;
          m_cyc = (m_cyc == 13) ? 0 : m_cyc + 1;
          m_pix = exp_pix(m_cyc);
        end else m_pos++;
        if (m_half == 14335) begin m_half = 0; m_ph = ~m_ph; end
        else m_half++;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(cur_tag, "row_sel", 32'(row_sel), 32'(e_row));
      check(cur_tag, "col_en",  32'(col_en),  32'(e_col));
      check(cur_tag, "clk_out", 32'(clk_out), 32'(e_clk));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run(3);
    rst = 1'b0;
  endtask

  task automatic fill_random();
    for (int d = 0; d < 8; d++)
      codes[d] = ($urandom % 4 == 0) ? {4'b1000, 4'($urandom)} : {1'b0, 7'($urandom % 96 + 32)};
    for (int g = 0; g < 16; g++)
      for (int r = 0; r < 7; r++) glyph[g][r] = 5'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; clk_sel = 1'b0; ext_tick = 1'b1; attr = '0; flash = '0;
    for (int d = 0; d < 8; d++) codes[d] = 8'h20;
    for (int g = 0; g < 16; g++)
      for (int r = 0; r < 7; r++) glyph[g][r] = '0;
    run(3);
    check("R1", "row_sel in reset", 32'(row_sel), 32'd0);
    check("R1", "col_en in reset", 32'(col_en), 32'd0);
    chk_on = 1;
    fill_random();
    rst = 1'b0;
    @(negedge clk);
    check("R2", "row_sel first cycle", 32'(row_sel), 32'h1);
    check("R8", "first cycle dark", 32'(col_en), 32'd0);

    cur_tag = "R3"; run(448);
    // directed: space codes and one custom glyph in group 0
    codes[0] = 8'h20; codes[1] = 8'h85; codes[2] = 8'h41; codes[3] = 8'h20;
    glyph[5][0] = 5'b10000; glyph[5][3] = 5'b11111;
    run(448);

    cur_tag = "R4";
    for (int lvl = 0; lvl < 8; lvl++) begin
      attr = 5'(lvl);
      run(224);
    end
    attr = 5'b00111;
    run(40);
    check("R4", "blank level dark", 32'(col_en), 32'd0);
    attr = '0;

    cur_tag = "R2";
    for (int i = 0; i < 800; i++) begin
      ext_tick = 1'($urandom);
      @(negedge clk);
    end
    ext_tick = 1'b1;

    cur_tag = "R8";
    for (int i = 0; i < 6; i++) begin
      while (m_pos != 5) @(negedge clk);
      fill_random();
      run(40);
    end

    cur_tag = "R9";
    clk_sel = 1'b1;
    do_reset();
    for (int i = 0; i < 1200; i++) begin
      ext_tick = 1'($urandom);
      @(negedge clk);
    end
    clk_sel = 1'b0; ext_tick = 1'b1;

    cur_tag = "R5";
    do_reset();
    attr = 5'b01000; flash = 8'hA5;
    for (int d = 0; d < 8; d++) codes[d] = {1'b0, 7'($urandom % 95 + 33)};
    run(20000);
    cur_tag = "R6";
    attr = 5'b11000;
    run(2000);
    cur_tag = "R7";
    attr = 5'b01010;
    run(8000);
    cur_tag = "R5";
    attr = 5'b00000;
    run(300);

    cur_tag = "R1";
    fill_random();
    rst = 1'b1;
    run(2);
    check("R1", "row_sel after mid-run reset", 32'(row_sel), 32'd0);
    check("R1", "col_en after mid-run reset", 32'(col_en), 32'd0);
    rst = 1'b0;
    run(500);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule